// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns host characters into asynchronous serial frames on a single output line. It has two storage stages: a holding register that takes the next character from the host, and a frame shifter that drives the current character onto the line. When a frame ends and a character is waiting, the shifter reloads from the holding register on that same clock edge, so consecutive frames follow each other with no idle gap. The host needs to write only when the empty flag is high.

The clock input is the transmit clock. A bit lasts 1, 16 or 64 of its cycles, chosen by a select input. The line register updates on the falling edge of that clock. The frame format (7 or 8 data bits, optional even or odd parity, 1 or 2 stop bits) is taken from a format input when each frame is loaded. The empty flag is forced low while clear-to-send is inactive or while the block is held in its synchronous reset.

Top module: `serial_tx_core`

## Requirements
- R1: After the asynchronous reset is released with cts_ni low and hold_rst_i low, txd_o is high (mark) and empty_o is high.
- R2: A frame is one low start bit, then the data bits LSB first, then the stop bit(s), which are high. The line idles high between frames.
- R3: fmt_i[0]=1 selects 8 data bits and fmt_i[0]=0 selects 7 (wdata_i[7] is not sent). fmt_i[1]=1 adds a parity bit after the data. With fmt_i[2]=0 the parity bit equals the XOR of the sent data bits (even parity). With fmt_i[2]=1 it equals the inverted XOR (odd parity).
- R4: fmt_i[3]=1 sends two stop bits and fmt_i[3]=0 sends one.
- R5: div_sel_i selects the bit length: 2'b00 gives 1 clock cycle, 2'b01 gives 16, and 2'b10 or 2'b11 give 64. Every bit, the start bit included, lasts exactly that many cycles.
- R6: A write (wr_i high at a rising edge) drives empty_o low in the next cycle. A character written while a frame is in progress starts right after that frame's last stop bit, with no idle cycle between the frames.
- R7: While cts_ni is high, empty_o is low whatever the buffer state. When cts_ni returns low, empty_o shows the real state of the holding register again.
- R8: While hold_rst_i is high, empty_o is low, both buffers are cleared and txd_o is high from the second falling edge after hold_rst_i is first sampled. No frame resumes after hold_rst_i is released.
- R9: txd_o changes only on falling edges of clk_i.
- R10: A write while the holding register is full replaces the waiting character. Only the last character written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock; line data updates on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_rst_i | input | 1 | Synchronous hold-in-reset, active high |
| cts_ni | input | 1 | Clear-to-send, active low |
| div_sel_i | input | 2 | Bit length select: 00 = 1, 01 = 16, 1x = 64 cycles |
| fmt_i | input | 4 | [0] 8 data bits, [1] parity on, [2] odd parity, [3] two stops |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Character to transmit |
| txd_o | output | 1 | Serial line, idles high |
| empty_o | output | 1 | Holding register empty, qualified by cts_ni and hold_rst_i |

## Verification
Single frames with random data, format and divide setting show whether bit order, parity polarity, data length and stop count are right. Directed cases cover the rest. A write made during a running frame shows whether the next start bit follows with no gap. Two writes during one frame show that the earlier character is replaced. A measurement of the start-bit length at each divide setting tells 1, 16 and 64 apart. Toggling clear-to-send and hold-in-reset at idle and in the middle of a frame separates the real buffer state from the qualified flag and shows whether a frame in flight is cut off.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic data8;
  } tx_fmt_t;

  typedef enum logic [1:0] {
    DIV_ONE   = 2'b00,
    DIV_MID   = 2'b01,
    DIV_HI    = 2'b10,
    DIV_HI_B  = 2'b11
  } div_sel_e;

  // bit 0 leaves first; unused upper positions stay at mark
  function automatic logic [FRAME_W-1:0] pack_frame(logic [DATA_W-1:0] d, tx_fmt_t f);
    logic [FRAME_W-1:0] v;
    logic par;
    int unsigned p;
    v    = '1;
    v[0] = 1'b0;
    p    = 1;
    par  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (f.data8 || (i < DATA_W - 1)) begin
        v[p] = d[i];
        par  = par ^ d[i];
        p    = p + 1;
      end
    end
    if (f.par_en) v[p] = par ^ f.par_odd;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(tx_fmt_t f);
    int unsigned n;
    n = 1 + (f.data8 ? DATA_W : DATA_W - 1) + (f.par_en ? 1 : 0) + (f.two_stop ? 2 : 1);
    return CNT_W'(n);
  endfunction
endpackage

// File: rtl/tx_baud_div.sv
module tx_baud_div
  import serial_tx_pkg::*;
#(
  parameter int unsigned DIV_MID_N = 16,
  parameter int unsigned DIV_HI_N  = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     restart_i,
  input  div_sel_e sel_i,
  output logic     tick_o
);
  localparam int unsigned CW = $clog2(DIV_HI_N);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    case (sel_i)
      DIV_ONE: lim = '0;
      DIV_MID: lim = CW'(DIV_MID_N - 1);
      default: lim = CW'(DIV_HI_N - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (cnt_q == lim)         cnt_q <= '0;
    else                           cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = run_i && (cnt_q == lim);

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R5
  AST_DIV_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (wr_i) begin
      valid_o <= 1'b1;      // write wins over a same-cycle transfer
      data_o  <= wdata_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_WR_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> valid_o); // R6
  AST_WR_OVERWRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (data_o == $past(wdata_i))); // R10
  AST_TAKE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i && !clr_i) |=> !valid_o); // R6
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  tx_fmt_t           fmt_i,
  input  div_sel_e          div_sel_i,
  input  logic              tick_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              line_o,
  output div_sel_e          div_sel_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  div_sel_e           sel_q;
  logic               last_bit_end;

  assign last_bit_end = busy_q && tick_i && (left_q == CNT_W'(1));
  assign load_o       = hold_valid_i && !clr_i && (!busy_q || last_bit_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      sel_q   <= DIV_ONE;
    end else if (clr_i) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_o) begin
      frame_q <= pack_frame(hold_data_i, fmt_i);
      left_q  <= frame_len(fmt_i);
      busy_q  <= 1'b1;
      sel_q   <= div_sel_i;
    end else if (busy_q && tick_i) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign line_o    = busy_q ? frame_q[0] : 1'b1;
  assign div_sel_o = sel_q;

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_o); // R2
  AST_CLR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_q); // R8
  AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0) && (left_q <= CNT_W'(FRAME_W))); // R2
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_bit_end && hold_valid_i && !clr_i) |=> (busy_q && !line_o)); // R6
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int unsigned DIV_MID_N = 16,
  parameter int unsigned DIV_HI_N  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_rst_i,
  input  logic       cts_ni,
  input  logic [1:0] div_sel_i,
  input  logic [3:0] fmt_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       txd_o,
  output logic       empty_o
);
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              busy;
  logic              line;
  logic              tick;
  div_sel_e          run_sel;

  tx_hold_reg u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hold_rst_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (load),
    .valid_o (hold_valid),
    .data_o  (hold_data)
  );

  tx_frame_shift u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (hold_rst_i),
    .hold_valid_i (hold_valid),
    .hold_data_i  (hold_data),
    .fmt_i        (tx_fmt_t'(fmt_i)),
    .div_sel_i    (div_sel_e'(div_sel_i)),
    .tick_i       (tick),
    .load_o       (load),
    .busy_o       (busy),
    .line_o       (line),
    .div_sel_o    (run_sel)
  );

  tx_baud_div #(
    .DIV_MID_N (DIV_MID_N),
    .DIV_HI_N  (DIV_HI_N)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .restart_i (load),
    .sel_i     (run_sel),
    .tick_o    (tick)
  );

  // line data launches on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_o <= 1'b1;
    else         txd_o <= line;
  end

  assign empty_o = !hold_valid && !cts_ni && !hold_rst_i;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hold_rst_i) |=> !empty_o); // R6
  AST_HOLD_RST_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_rst_i) |-> txd_o); // R8
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!busy) && !busy) |-> txd_o); // R2
endmodule

// File: tb/sim_serial_tx_core.sv
`timescale 1ns/1ps
module sim_serial_tx_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hold_rst_i = 1'b0;
  logic       cts_ni = 1'b0;
  logic [1:0] div_sel_i = 2'b00;
  logic [3:0] fmt_i = 4'b0001;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       txd_o;
  logic       empty_o;

  int checks = 0;
  int errors = 0;
  int r9_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  serial_tx_core u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int ratio(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 16 : 64;
  endfunction

  function automatic void exp_frame(input logic [7:0] d, input logic [3:0] f,
                                    output logic [11:0] b, output int n);
    int k;
    int nd;
    logic p;
    b = '1; b[0] = 1'b0; k = 1; p = 1'b0;
    nd = f[0] ? 8 : 7;
    for (int i = 0; i < nd; i++) begin
      b[k] = d[i]; p = p ^ d[i]; k++;
    end
    if (f[1]) begin b[k] = p ^ f[2]; k++; end
    k = k + (f[3] ? 2 : 1);
    n = k;
  endfunction

  // R9: line must be stable between a rising edge and the following falling edge
  always begin
    logic v;
    @(posedge clk_i);
    v = txd_o;
    #2;
    if (rst_ni && txd_o !== v) r9_bad++;
  end

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  task automatic write_char(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wait_start(input int limit, output bit found);
    found = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i); #1;
      if (txd_o == 1'b0) begin found = 1; break; end
    end
  endtask

  // on return: 1 ns after the falling edge where the next bit would begin
  task automatic check_frame(input string req, input logic [7:0] d, input logic [3:0] f,
                             input logic [1:0] s, input bit at_start);
    logic [11:0] b;
    int n;
    int nr;
    bit found;
    exp_frame(d, f, b, n);
    nr = ratio(s);
    if (!at_start) begin
      wait_start(2000, found);
      chk({req, " start seen"}, found, 1);
      if (!found) return;
    end
    repeat (nr / 2) @(negedge clk_i);
    #1;
    chk({req, " bit0"}, txd_o, b[0]);
    for (int i = 1; i < n; i++) begin
      repeat (nr) @(negedge clk_i);
      #1;
      chk($sformatf("%s bit%0d", req, i), txd_o, b[i]);
    end
    repeat (nr - nr / 2) @(negedge clk_i);
    #1;
  endtask

  task automatic measure_start(input logic [1:0] s);
    bit found;
    int cnt;
    div_sel_i = s; fmt_i = 4'b0001;
    write_char(8'hFF);
    wait_start(200, found);
    cnt = 1;
    while (found && cnt < 200) begin
      @(negedge clk_i); #1;
      if (txd_o == 1'b1) break;
      cnt++;
    end
    chk($sformatf("R5 start length sel=%0d", s), cnt, ratio(s));
    repeat (12 * ratio(s) + 8) @(negedge clk_i);
  endtask

  initial begin
    bit found;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 txd in reset", txd_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 txd after reset", txd_o, 1);
    chk("R1 empty after reset", empty_o, 1);

    // R2: 8N1, fast clock
    div_sel_i = 2'b00; fmt_i = 4'b0001;
    write_char(8'hA5);
    check_frame("R2 8N1", 8'hA5, 4'b0001, 2'b00, 0);
    chk("R2 idle high", txd_o, 1);

    // R3: 7 data bits with even, then odd parity; bit 7 not sent
    div_sel_i = 2'b01; fmt_i = 4'b0010;
    write_char(8'hC3);
    check_frame("R3 7E1", 8'hC3, 4'b0010, 2'b01, 0);
    fmt_i = 4'b0110;
    write_char(8'h96);
    check_frame("R3 7O1", 8'h96, 4'b0110, 2'b01, 0);

    // R4: 8 data, odd parity, two stops
    div_sel_i = 2'b00; fmt_i = 4'b1111;
    write_char(8'h3C);
    check_frame("R4 8O2", 8'h3C, 4'b1111, 2'b00, 0);

    // R5: start-bit length for each select code
    measure_start(2'b00);
    measure_start(2'b01);
    measure_start(2'b10);
    measure_start(2'b11);

    // R6: second write during a frame follows with no gap
    div_sel_i = 2'b01; fmt_i = 4'b0001;
    write_char(8'h5A);
    fork
      check_frame("R6 first", 8'h5A, 4'b0001, 2'b01, 0);
      begin
        write_char(8'h81);
        #1;
        chk("R6 empty low after write", empty_o, 0);
      end
    join
    check_frame("R6 back-to-back", 8'h81, 4'b0001, 2'b01, 1);
    chk("R6 empty high after drain", empty_o, 1);

    // R10: overwrite of a waiting character
    div_sel_i = 2'b00; fmt_i = 4'b1001;
    write_char(8'h11);
    fork
      check_frame("R10 first", 8'h11, 4'b1001, 2'b00, 0);
      begin
        write_char(8'h22);
        write_char(8'hE7);
      end
    join
    check_frame("R10 replacement", 8'hE7, 4'b1001, 2'b00, 1);
    wait_start(40, found);
    chk("R10 replaced char not sent", found, 0);

    // R7: clear-to-send masks the flag
    @(negedge clk_i);
    cts_ni = 1'b1; #1;
    chk("R7 empty masked at idle", empty_o, 0);
    write_char(8'h44);
    #1;
    chk("R7 empty masked while full", empty_o, 0);
    check_frame("R7 frame with cts high", 8'h44, 4'b1001, 2'b00, 0);
    cts_ni = 1'b0; #1;
    chk("R7 empty restored", empty_o, 1);

    // R8: hold-in-reset in the middle of a frame
    div_sel_i = 2'b01; fmt_i = 4'b0001;
    write_char(8'h00);
    write_char(8'hFF);
    wait_start(200, found);
    repeat (20) @(negedge clk_i);
    hold_rst_i = 1'b1;
    #1;
    chk("R8 empty low in hold", empty_o, 0);
    repeat (2) @(negedge clk_i);
    #1;
    chk("R8 line mark in hold", txd_o, 1);
    repeat (30) @(negedge clk_i);
    #1;
    chk("R8 line stays mark", txd_o, 1);
    hold_rst_i = 1'b0;
    #1;
    chk("R8 empty after release", empty_o, 1);
    wait_start(300, found);
    chk("R8 no frame resumes", found, 0);

    // random frames
    for (int it = 0; it < 24; it++) begin
      logic [7:0] d;
      logic [3:0] f;
      logic [1:0] s;
      string tag;
      d = 8'($urandom);
      f = 4'($urandom);
      s = 2'($urandom);
      tag = f[1] ? "R3 rand" : (f[3] ? "R4 rand" : "R2 rand");
      div_sel_i = s; fmt_i = f;
      write_char(d);
      check_frame(tag, d, f, s, 0);
      chk("R2 rand idle", txd_o, 1);
    end

    chk("R9 line moves only on falling edge", r9_bad, 0);
    done = 1;
    summary();
  end
endmodule